// File: doc/BRIEF.md
# Interrupt Flag and Priority Offset Encoder

This block gathers interrupt events from a timer coprocessor and condenses them into two prioritised request lines for a host CPU. There are 32 instruction flag slots, plus three special sources: program overflow, address-counter underflow and address-counter overflow. An instruction event picks its slot from the low bits of the program address, so addresses a multiple of 32 apart share one flag. Every flag is sticky, and it is set whether or not its source is enabled.

Each source is mapped by a level register to one of two priority levels. A source is pending in its level when its flag and its enable are both 1. Each level drives a request line. Each level also shows an offset code that names its lowest-numbered pending source. The host services a level by reading that offset through a small register port, and the read clears the flag it names. The host can also clear flags directly with a write-one-to-clear.

Top module: `tie_irq_encoder`

## Requirements
- R1: An instruction strobe sets a flag only in a cycle where `ins_evt`, `ins_cond` and `ins_ien` are all 1.
- R2: The flag an instruction event sets is bit `ins_addr[4:0]`, so addresses that differ by a multiple of 32 set the same flag.
- R3: Flags are set independently of the enable mask. Register 0 reads the 35 flags: bit i for slot i (0..31), bit 32 program overflow, bit 33 address-counter underflow, bit 34 address-counter overflow.
- R4: Level register bit i = 0 places source i in level 1, and 1 places it in level 2. A level's request output is 1 exactly when some source in that level has both its flag and its enable at 1.
- R5: Each level's offset is 0 when nothing is pending. Otherwise it is the index of the lowest-numbered pending source plus 1: 1..32 for slots 0..31, 33 for program overflow, 34 for underflow and 35 for overflow.
- R6: A host read of register 4 (level 1) or register 5 (level 2) returns that level's offset and clears the flag it names. A read that returns 0 clears nothing.
- R7: When an event and a clear (a write-one-to-clear or an offset read) hit the same flag in the same cycle, the flag ends up set.
- R8: Writing register 0 clears exactly the flags written with 1. Flags written with 0 keep their value.
- R9: A write to register 1 sets the enable bits written with 1. A write to register 2 clears them. Reads of register 1 and of register 2 both return the enable mask. Register 3 holds the level mask and reads it back.
- R10: After reset, all flags, enables and level bits are 0, and both request outputs and both offsets are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_evt | input | 1 | Instruction event strobe |
| ins_cond | input | 1 | Interrupt condition of the instruction is true |
| ins_ien | input | 1 | Interrupt-enable bit of the instruction |
| ins_addr | input | ADDR_W | Current program address |
| prog_ovf_evt | input | 1 | Program overflow strobe |
| acnt_unf_evt | input | 1 | Address-counter underflow strobe |
| acnt_ovf_evt | input | 1 | Address-counter overflow strobe |
| hw_en | input | 1 | Host write strobe |
| hw_addr | input | 3 | Host write register number |
| hw_wdata | input | NSRC | Host write data |
| hr_en | input | 1 | Host read strobe (offset reads take effect at the clock edge) |
| hr_addr | input | 3 | Host read register number |
| hr_rdata | output | NSRC | Host read data (combinational) |
| irq_lvl1 | output | 1 | Level 1 request |
| irq_lvl2 | output | 1 | Level 2 request |
| off_lvl1 | output | OFF_W | Level 1 offset code |
| off_lvl2 | output | OFF_W | Level 2 offset code |

## Verification
The hardest state to reach is one where many flags are pending at the same time, with levels interleaved and some enables off. Only then does the priority order show up, along with the effect of the read-to-clear. The stimulus sets all 35 flags, one event per cycle, with a level pattern that mixes both levels and a few disabled sources. It then drains each level by repeated offset reads and checks each returned code against the next expected source. Same-cycle collisions between an event and each kind of clear are driven on purpose. An all-address sweep of the event inputs covers the slot aliasing.

// File: rtl/tie_pkg.sv
package tie_pkg;
  typedef enum logic [2:0] {
    RA_FLAGS = 3'd0,
    RA_ENSET = 3'd1,
    RA_ENCLR = 3'd2,
    RA_LEVEL = 3'd3,
    RA_OFF1  = 3'd4,
    RA_OFF2  = 3'd5
  } tie_reg_e;

  // Offset code for source index idx (0 is reserved for "nothing pending").
  function automatic int code_of(input int idx);
    return idx + 1;
  endfunction
endpackage

// File: rtl/tie_evt_decode.sv
module tie_evt_decode #(
  parameter int SLOT_BITS = 5,
  parameter int ADDR_W    = 9,
  parameter int NSRC      = (1 << SLOT_BITS) + 3
) (
  input  logic              ins_evt,
  input  logic              ins_cond,
  input  logic              ins_ien,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic [2:0]        spec_evt,
  output logic [NSRC-1:0]   set_vec
);
  localparam int NSLOT = 1 << SLOT_BITS;

  logic ins_fire;
  assign ins_fire = ins_evt & ins_cond & ins_ien;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    assign set_vec[g] = ins_fire && (ins_addr[SLOT_BITS-1:0] == SLOT_BITS'(g));
  end
  assign set_vec[NSRC-1:NSLOT] = spec_evt;
endmodule

// File: rtl/tie_flag_bank.sv
module tie_flag_bank #(
  parameter int NSRC = 35
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_vec,
  input  logic [NSRC-1:0] clr_vec,
  output logic [NSRC-1:0] flag_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q & ~clr_vec) | set_vec;
  end
endmodule

// File: rtl/tie_prio_enc.sv
module tie_prio_enc #(
  parameter int NSRC  = 35,
  parameter int OFF_W = 6
) (
  input  logic [NSRC-1:0]  pend,
  output logic [OFF_W-1:0] off,
  output logic             any
);
  always_comb begin
    off = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend[i]) off = OFF_W'(tie_pkg::code_of(i));
    end
  end
  assign any = |pend;
endmodule

// File: rtl/tie_irq_encoder.sv
module tie_irq_encoder #(
  parameter int SLOT_BITS = 5,
  parameter int ADDR_W    = 9,
  localparam int NSRC     = (1 << SLOT_BITS) + 3,
  localparam int OFF_W    = $clog2(NSRC + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_evt,
  input  logic              ins_cond,
  input  logic              ins_ien,
  input  logic [ADDR_W-1:0] ins_addr,
  input  logic              prog_ovf_evt,
  input  logic              acnt_unf_evt,
  input  logic              acnt_ovf_evt,
  input  logic              hw_en,
  input  logic [2:0]        hw_addr,
  input  logic [NSRC-1:0]   hw_wdata,
  input  logic              hr_en,
  input  logic [2:0]        hr_addr,
  output logic [NSRC-1:0]   hr_rdata,
  output logic              irq_lvl1,
  output logic              irq_lvl2,
  output logic [OFF_W-1:0]  off_lvl1,
  output logic [OFF_W-1:0]  off_lvl2
);
  import tie_pkg::*;

  logic [NSRC-1:0]  set_vec, clr_vec, flag_q, en_q, lvl_q;
  logic [NSRC-1:0]  pend    [2];
  logic [NSRC-1:0]  rd_clr  [2];
  logic [OFF_W-1:0] off     [2];
  logic             any     [2];
  logic             rd_hit  [2];
  logic [NSRC-1:0]  rd_clr_l1, rd_clr_l2;
  logic [NSRC-1:0]  w1c_vec;

  tie_evt_decode #(.SLOT_BITS(SLOT_BITS), .ADDR_W(ADDR_W), .NSRC(NSRC)) u_dec (
    .ins_evt  (ins_evt),
    .ins_cond (ins_cond),
    .ins_ien  (ins_ien),
    .ins_addr (ins_addr),
    .spec_evt ({acnt_ovf_evt, acnt_unf_evt, prog_ovf_evt}),
    .set_vec  (set_vec)
  );

  tie_flag_bank #(.NSRC(NSRC)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .flag_q  (flag_q)
  );

  for (genvar k = 0; k < 2; k++) begin : g_lvl
    if (k == 0) begin : g_l1
      assign pend[k] = flag_q & en_q & ~lvl_q;
    end else begin : g_l2
      assign pend[k] = flag_q & en_q & lvl_q;
    end

    tie_prio_enc #(.NSRC(NSRC), .OFF_W(OFF_W)) u_enc (
      .pend (pend[k]),
      .off  (off[k]),
      .any  (any[k])
    );

    assign rd_hit[k] = hr_en && (hr_addr == 3'(RA_OFF1) + 3'(k));
    for (genvar i = 0; i < NSRC; i++) begin : g_bit
      assign rd_clr[k][i] = rd_hit[k] && (off[k] == OFF_W'(code_of(i)));
    end
  end

  assign rd_clr_l1 = rd_clr[0];
  assign rd_clr_l2 = rd_clr[1];
  assign w1c_vec   = (hw_en && hw_addr == RA_FLAGS) ? hw_wdata : '0;
  assign clr_vec   = w1c_vec | rd_clr_l1 | rd_clr_l2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q  <= '0;
      lvl_q <= '0;
    end else if (hw_en) begin
      case (hw_addr)
        RA_ENSET: en_q  <= en_q | hw_wdata;
        RA_ENCLR: en_q  <= en_q & ~hw_wdata;
        RA_LEVEL: lvl_q <= hw_wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (hr_addr)
      RA_FLAGS:          hr_rdata = flag_q;
      RA_ENSET, RA_ENCLR: hr_rdata = en_q;
      RA_LEVEL:          hr_rdata = lvl_q;
      RA_OFF1:           hr_rdata = NSRC'(off[0]);
      RA_OFF2:           hr_rdata = NSRC'(off[1]);
      default:           hr_rdata = '0;
    endcase
  end

  assign irq_lvl1 = any[0];
  assign irq_lvl2 = any[1];
  assign off_lvl1 = off[0];
  assign off_lvl2 = off[1];
endmodule

// File: rtl/tie_irq_chk.sv
module tie_irq_chk #(
  parameter int NSRC  = 35,
  parameter int OFF_W = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NSRC-1:0]  set_vec,
  input logic [NSRC-1:0]  clr_vec,
  input logic [NSRC-1:0]  flag_q,
  input logic [NSRC-1:0]  en_q,
  input logic [NSRC-1:0]  lvl_q,
  input logic [NSRC-1:0]  rd_clr_l1,
  input logic [NSRC-1:0]  rd_clr_l2,
  input logic [OFF_W-1:0] off1,
  input logic [OFF_W-1:0] off2,
  input logic             irq1,
  input logic             irq2
);
  p_set_sticks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (set_vec != '0) |=> ((flag_q & $past(set_vec)) == $past(set_vec)));

  p_drop_needs_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q != '0) |=> (($past(flag_q) & ~flag_q & ~$past(clr_vec)) == '0));

  p_off1_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (off1 != '0) |-> (flag_q[int'(off1) - 1] && en_q[int'(off1) - 1] && !lvl_q[int'(off1) - 1]));

  p_off2_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (off2 != '0) |-> (flag_q[int'(off2) - 1] && en_q[int'(off2) - 1] && lvl_q[int'(off2) - 1]));

  p_irq1_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq1 |-> (off1 != '0));

  p_off1_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (off1 != '0) |-> irq1);

  p_irq2_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq2 |-> (off2 != '0));

  p_rdclr_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(rd_clr_l1) && $onehot0(rd_clr_l2));

  p_rdclr_takes_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr_l1 != '0) |=> ((flag_q & $past(rd_clr_l1) & ~$past(set_vec)) == '0));
endmodule

bind tie_irq_encoder tie_irq_chk #(.NSRC(NSRC), .OFF_W(OFF_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .set_vec   (set_vec),
  .clr_vec   (clr_vec),
  .flag_q    (flag_q),
  .en_q      (en_q),
  .lvl_q     (lvl_q),
  .rd_clr_l1 (rd_clr_l1),
  .rd_clr_l2 (rd_clr_l2),
  .off1      (off_lvl1),
  .off2      (off_lvl2),
  .irq1      (irq_lvl1),
  .irq2      (irq_lvl2)
);

// File: tb/sim_tie_irq_encoder.sv
module sim_tie_irq_encoder;
  localparam int SB = 5;
  localparam int AW = 9;
  localparam int NS = 35;
  localparam int OW = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, ins_evt, ins_cond, ins_ien;
  logic [AW-1:0] ins_addr;
  logic prog_ovf_evt, acnt_unf_evt, acnt_ovf_evt;
  logic hw_en, hr_en;
  logic [2:0] hw_addr, hr_addr;
  logic [NS-1:0] hw_wdata, hr_rdata;
  logic irq_lvl1, irq_lvl2;
  logic [OW-1:0] off_lvl1, off_lvl2;

  tie_irq_encoder #(.SLOT_BITS(SB), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .ins_evt(ins_evt), .ins_cond(ins_cond),
    .ins_ien(ins_ien), .ins_addr(ins_addr), .prog_ovf_evt(prog_ovf_evt),
    .acnt_unf_evt(acnt_unf_evt), .acnt_ovf_evt(acnt_ovf_evt),
    .hw_en(hw_en), .hw_addr(hw_addr), .hw_wdata(hw_wdata),
    .hr_en(hr_en), .hr_addr(hr_addr), .hr_rdata(hr_rdata),
    .irq_lvl1(irq_lvl1), .irq_lvl2(irq_lvl2),
    .off_lvl1(off_lvl1), .off_lvl2(off_lvl2)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [NS-1:0] mflag, men, mlvl;
  localparam logic [NS-1:0] ALL = '1;

  // reference: smallest set bit position plus one, scanned from the top down
  function automatic int ref_off(input logic [NS-1:0] v);
    int r = 0;
    for (int i = NS - 1; i >= 0; i--) if (v[i]) r = i + 1;
    return r;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [NS-1:0] d);
    hw_en = 1'b1; hw_addr = a; hw_wdata = d;
    tick();
    hw_en = 1'b0; hw_wdata = '0;
    case (a)
      3'd0: mflag &= ~d;
      3'd1: men |= d;
      3'd2: men &= ~d;
      3'd3: mlvl = d;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [2:0] a, output logic [NS-1:0] d);
    hr_en = 1'b1; hr_addr = a;
    #1 d = hr_rdata;
    tick();
    hr_en = 1'b0;
    if ((a == 3'd4 || a == 3'd5) && d != '0) mflag[int'(d) - 1] = 1'b0;
  endtask

  task automatic ins(input int a, input logic c, input logic ie);
    ins_evt = 1'b1; ins_addr = AW'(a); ins_cond = c; ins_ien = ie;
    tick();
    ins_evt = 1'b0; ins_cond = 1'b0; ins_ien = 1'b0;
    if (c && ie) mflag[a % 32] = 1'b1;
  endtask

  task automatic spec(input int k);
    prog_ovf_evt = (k == 0); acnt_unf_evt = (k == 1); acnt_ovf_evt = (k == 2);
    tick();
    prog_ovf_evt = 1'b0; acnt_unf_evt = 1'b0; acnt_ovf_evt = 1'b0;
    mflag[32 + k] = 1'b1;
  endtask

  task automatic check_outs(input string req);
    logic [NS-1:0] p1, p2;
    p1 = mflag & men & ~mlvl;
    p2 = mflag & men & mlvl;
    chk({req, " off1"}, 64'(off_lvl1), 64'(ref_off(p1)));
    chk({req, " off2"}, 64'(off_lvl2), 64'(ref_off(p2)));
    chk({req, " irq1"}, 64'(irq_lvl1), 64'(p1 != '0));
    chk({req, " irq2"}, 64'(irq_lvl2), 64'(p2 != '0));
  endtask

  task automatic check_flags(input string req);
    logic [NS-1:0] d;
    rd(3'd0, d);
    chk({req, " flags"}, 64'(d), 64'(mflag));
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    logic [NS-1:0] d;
    int e;
    rst_n = 1'b0; ins_evt = 0; ins_cond = 0; ins_ien = 0; ins_addr = '0;
    prog_ovf_evt = 0; acnt_unf_evt = 0; acnt_ovf_evt = 0;
    hw_en = 0; hr_en = 0; hw_addr = '0; hr_addr = '0; hw_wdata = '0;
    mflag = '0; men = '0; mlvl = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R10 reset state
    check_outs("R10");
    check_flags("R10");
    rd(3'd1, d); chk("R10 enable", 64'(d), 64'(0));
    rd(3'd3, d); chk("R10 level", 64'(d), 64'(0));

    // R1 R2 R3: all addresses, all qualifier combinations, enables off
    for (int a = 0; a < (1 << AW); a++) begin
      for (int c = 0; c < 4; c++) begin
        ins(a, c[0], c[1]);
        check_flags("R1 R2");
        chk("R3 no irq while disabled", 64'({irq_lvl1, irq_lvl2}), 64'(0));
        wr(3'd0, ALL);
      end
    end
    // strobe low with qualifiers high sets nothing (R1)
    ins_cond = 1'b1; ins_ien = 1'b1; ins_addr = AW'(9);
    tick();
    ins_cond = 1'b0; ins_ien = 1'b0;
    check_flags("R1 strobe low");

    // R2 aliasing of 3, 35, 67
    ins(3, 1, 1); ins(35, 1, 1); ins(67, 1, 1);
    rd(3'd0, d); chk("R2 alias", 64'(d), 64'(1) << 3);
    mflag = d;
    // R3 specials land at bits 32..34
    for (int k = 0; k < 3; k++) spec(k);
    check_flags("R3 specials");
    check_outs("R3");
    wr(3'd0, ALL);

    // R9 enable set/clear/readback
    wr(3'd1, 35'h5_A5A5_0F0F);
    rd(3'd1, d); chk("R9 set read", 64'(d), 64'(men));
    rd(3'd2, d); chk("R9 clr read", 64'(d), 64'(men));
    wr(3'd2, 35'h0_0000_0F00);
    rd(3'd1, d); chk("R9 after clear", 64'(d), 64'(men));
    wr(3'd3, 35'h2_1234_5678);
    rd(3'd3, d); chk("R9 level read", 64'(d), 64'(mlvl));

    // R5 specials alone in level 1
    wr(3'd3, '0); wr(3'd1, ALL);
    for (int k = 0; k < 3; k++) begin
      spec(k);
      chk("R5 special code", 64'(off_lvl1), 64'(33 + k));
      wr(3'd0, ALL);
    end

    // R4 R5 R6: fill everything, interleaved levels, a few disabled, drain
    for (int i = 0; i < NS; i++) d[i] = (i % 3 == 0);
    wr(3'd3, d);
    wr(3'd2, 35'h4_0000_0005);
    for (int i = 0; i < 32; i++) ins(i + 64, 1, 1);
    for (int k = 0; k < 3; k++) spec(k);
    check_outs("R4 full");
    for (int lv = 0; lv < 2; lv++) begin
      for (int n = 0; n < NS; n++) begin
        e = ref_off(mflag & men & (lv == 0 ? ~mlvl : mlvl));
        if (e == 0) break;
        rd(3'(4 + lv), d);
        chk("R6 read code", 64'(d), 64'(e));
        check_outs("R5 drain");
      end
      rd(3'(4 + lv), d);
      chk("R6 empty read", 64'(d), 64'(0));
      check_flags("R6 empty read keeps flags");
    end
    chk("R4 drained", 64'({irq_lvl1, irq_lvl2}), 64'(0));
    wr(3'd0, ALL);
    check_flags("R8 all clear");

    // R7: event and write-one-to-clear collide on slot 7
    wr(3'd3, '0);
    ins(7, 1, 1);
    ins_evt = 1; ins_cond = 1; ins_ien = 1; ins_addr = AW'(7);
    hw_en = 1; hw_addr = 3'd0; hw_wdata = 35'h80;
    tick();
    ins_evt = 0; ins_cond = 0; ins_ien = 0; hw_en = 0; hw_wdata = '0;
    check_flags("R7 w1c collision");
    // R7: event and offset read collide on slot 7
    ins_evt = 1; ins_cond = 1; ins_ien = 1; ins_addr = AW'(7);
    hr_en = 1; hr_addr = 3'd4;
    #1 chk("R7 read code", 64'(hr_rdata), 64'(8));
    tick();
    ins_evt = 0; ins_cond = 0; ins_ien = 0; hr_en = 0;
    check_flags("R7 read collision");
    check_outs("R7");

    // R8: zeros do not clear, ones clear only their bits
    ins(9, 1, 1);
    wr(3'd0, '0);
    check_flags("R8 zero write");
    wr(3'd0, 35'h200);
    check_flags("R8 single bit");
    check_outs("R8");

    summary();
    $finish;
  end
endmodule